// File: doc/BRIEF.md
# Matrix Job Configuration Register File

This block is the software-facing control point of a matrix-operation accelerator. A host writes it over a simple 32-bit request/response bus that carries address, write enable, byte enables, write data and read data. Through that bus the host sets the base addresses of the two source matrices (X and W) and of the accumulate/result matrix (Z), the three matrix dimensions, and an arithmetic control word. The arithmetic word selects the operation, the tensor data format and a custom-format flag.

Once the job is described, the host writes a trigger location. The block then gives the datapath a one-cycle start pulse and reports busy in its status word. It drops busy when the datapath returns a one-cycle done pulse, and from then on it holds a sticky done flag that also drives a single done output. While a job runs, configuration writes and further triggers are ignored. A soft-clear write returns every register and every state bit to zero, whether or not a job is running.

Top module: `mmjob_cfg_regs`

## Requirements
- R1: Offsets 0x40, 0x44 and 0x48 are 32-bit read/write base-address registers for X, W and Z. On a write, byte enable bit i updates data bits [8i+7:8i] only.
- R2: Offset 0x4C holds K in bits [31:16] and M in bits [15:0]. Offset 0x50 holds N across all 32 bits. Both follow the byte-enable rule of R1.
- R3: Offset 0x54 keeps only bit 14 (custom format), bits [12:10] (operation, 3'b001 = GEMM) and bits [9:7] (format, 3'b001 = FP16). Every other bit reads back as zero, so writing all ones reads back 0x00005F80.
- R4: A write to offset 0x00 while idle pulses dp_start high for exactly one cycle, in the cycle after the request. In that same cycle busy is set and done is cleared.
- R5: A write to offset 0x00 while busy gives no dp_start pulse and leaves the status unchanged.
- R6: A dp_done pulse while busy clears busy and sets done in the next cycle. done stays set until the next accepted trigger or soft clear, and irq_done equals done. A dp_done pulse while idle has no effect.
- R7: Writes to offsets 0x40 to 0x54 while busy are ignored, and the registers keep their previous contents.
- R8: A write to offset 0x04 clears all configuration registers, busy, done and dp_start in the next cycle, including while busy.
- R9: Offset 0x0C is read-only status: bit 0 = busy, bit 1 = done, all other bits zero.
- R10: Every request receives rsp_valid exactly one cycle later. Reads return the register value as it was before that cycle's edge. Reads of unmapped offsets and all write responses return zero.
- R11: After reset, all registers read zero, busy and done are zero, and dp_start, irq_done and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the request |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data (zero for writes and unmapped offsets) |
| dp_start | output | 1 | One-cycle job start toward the datapath |
| dp_done | input | 1 | One-cycle job completion from the datapath |
| irq_done | output | 1 | Level copy of the sticky done flag |

## Verification
A corrupted configuration word shows up on the very next read of its offset, which answers one cycle after the request. The bench therefore reads back every write, including partial byte-enable writes and the masked arithmetic word. A wrong busy or done bit shows in the cycle after the event that should have set it, either on dp_start and irq_done directly or in the next status read. The bench samples both right after each trigger, done pulse and soft clear. Writes and triggers made during a job, and done pulses made while idle, are each followed by a read-back, so a lost freeze or a stray state change becomes visible.

// File: rtl/mmjob_pkg.sv
package mmjob_pkg;
    localparam int DATA_W   = 32;
    localparam int BE_W     = DATA_W / 8;
    localparam int ADDR_W   = 8;
    localparam int WIDX_W   = ADDR_W - 2;
    localparam int NUM_CFG  = 6;
    localparam int CIDX_W   = $clog2(NUM_CFG);
    localparam int ARITH_IDX = 5;

    localparam logic [WIDX_W-1:0] W_TRIG  = WIDX_W'(8'h00 >> 2);
    localparam logic [WIDX_W-1:0] W_CLR   = WIDX_W'(8'h04 >> 2);
    localparam logic [WIDX_W-1:0] W_STAT  = WIDX_W'(8'h0C >> 2);
    localparam logic [WIDX_W-1:0] W_CFG0  = WIDX_W'(8'h40 >> 2);

    localparam logic [DATA_W-1:0] ARITH_MASK = 32'h0000_5F80;

    typedef struct packed {
        logic              trig;
        logic              clr;
        logic              stat;
        logic              cfg;
        logic [CIDX_W-1:0] cidx;
    } dec_t;

    function automatic logic [DATA_W-1:0] cfg_mask(input int idx);
        return (idx == ARITH_IDX) ? ARITH_MASK : {DATA_W{1'b1}};
    endfunction

    function automatic logic [DATA_W-1:0] merge_be(input logic [DATA_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] new_v,
                                                   input logic [BE_W-1:0]   be);
        logic [DATA_W-1:0] r;
        for (int b = 0; b < BE_W; b++)
            r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
        return r;
    endfunction
endpackage

// File: rtl/mmjob_decode.sv
module mmjob_decode
    import mmjob_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [WIDX_W-1:0] widx;
    logic [WIDX_W-1:0] rel;

    always_comb begin
        widx      = addr[ADDR_W-1:2];
        rel       = widx - W_CFG0;
        dec.trig  = (widx == W_TRIG);
        dec.clr   = (widx == W_CLR);
        dec.stat  = (widx == W_STAT);
        dec.cfg   = (widx >= W_CFG0) && (rel < WIDX_W'(NUM_CFG));
        dec.cidx  = rel[CIDX_W-1:0];
    end
endmodule

// File: rtl/mmjob_cfg_store.sv
module mmjob_cfg_store
    import mmjob_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic                          busy,
    input  logic                          wr,
    input  logic [CIDX_W-1:0]             cidx,
    input  logic [BE_W-1:0]               be,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q
);
    logic wr_ok;
    assign wr_ok = wr && !busy;

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst || clr)
                cfg_q[g] <= '0;
            else if (wr_ok && (cidx == CIDX_W'(g)))
                cfg_q[g] <= merge_be(cfg_q[g], wdata, be) & cfg_mask(g);
        end
    end

    // R3: reserved arithmetic bits never hold a one
    a_r3_arith_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[ARITH_IDX] & ~ARITH_MASK) == '0);
    // R7: configuration frozen during a job
    a_r7_cfg_frozen_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !clr) |=> $stable(cfg_q));
    // R8: soft clear empties every configuration word
    a_r8_cfg_cleared: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cfg_q == '0));
endmodule

// File: rtl/mmjob_ctrl.sv
module mmjob_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic trig_wr,
    input  logic clr_wr,
    input  logic dp_done,
    output logic busy,
    output logic done,
    output logic dp_start
);
    logic accept;
    assign accept = trig_wr && !busy;

    always_ff @(posedge clk) begin
        if (rst || clr_wr) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            dp_start <= 1'b0;
        end else begin
            dp_start <= accept;
            if (accept) begin
                busy <= 1'b1;
                done <= 1'b0;
            end else if (dp_done && busy) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    // R4: start lasts one cycle and comes with busy set, done cleared
    a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
        dp_start |=> !dp_start);
    a_r4_start_busy: assert property (@(posedge clk) disable iff (rst)
        (trig_wr && !busy && !clr_wr) |=> (dp_start && busy && !done));
    // R5: trigger during a job is dropped
    a_r5_trig_busy_ignored: assert property (@(posedge clk) disable iff (rst)
        (trig_wr && busy && !clr_wr) |=> (!dp_start && busy));
    // R6: completion handling
    a_r6_done_sets: assert property (@(posedge clk) disable iff (rst)
        (dp_done && busy && !clr_wr) |=> (!busy && done));
    a_r6_idle_done_noeffect: assert property (@(posedge clk) disable iff (rst)
        (dp_done && !busy && !trig_wr && !clr_wr) |=> ($stable(done) && !busy));
    // R8: soft clear drops all state
    a_r8_state_cleared: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> (!busy && !done && !dp_start));
endmodule

// File: rtl/mmjob_cfg_regs.sv
module mmjob_cfg_regs
    import mmjob_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dp_start,
    input  logic              dp_done,
    output logic              irq_done
);
    dec_t dec;
    logic busy, done;
    logic wr_any, rd_any;
    logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] rd_word;

    assign wr_any = req_valid && req_we;
    assign rd_any = req_valid && !req_we;

    mmjob_decode u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    mmjob_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .trig_wr  (wr_any && dec.trig),
        .clr_wr   (wr_any && dec.clr),
        .dp_done  (dp_done),
        .busy     (busy),
        .done     (done),
        .dp_start (dp_start)
    );

    mmjob_cfg_store u_store (
        .clk   (clk),
        .rst   (rst),
        .clr   (wr_any && dec.clr),
        .busy  (busy),
        .wr    (wr_any && dec.cfg),
        .cidx  (dec.cidx),
        .be    (req_be),
        .wdata (req_wdata),
        .cfg_q (cfg_q)
    );

    always_comb begin
        rd_word = '0;
        if (dec.stat)
            rd_word = {{(DATA_W-2){1'b0}}, done, busy};
        else if (dec.cfg)
            rd_word = cfg_q[dec.cidx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= rd_any ? rd_word : '0;
        end
    end

    assign irq_done = done;

    // R10: one response per request, one cycle later; writes answer zero
    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    a_r10_write_rsp_zero: assert property (@(posedge clk) disable iff (rst)
        wr_any |=> (rsp_rdata == '0));
    // R9: status read reflects only two live bits
    a_r9_status_bits: assert property (@(posedge clk) disable iff (rst)
        (rd_any && dec.stat) |=> (rsp_rdata[DATA_W-1:2] == '0));
endmodule

// File: tb/sim_mmjob_cfg_regs.sv
module sim_mmjob_cfg_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        dp_start, dp_done = 1'b0, irq_done;

    int checks = 0, errors = 0, cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mmjob_cfg_regs u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dp_start(dp_start), .dp_done(dp_done), .irq_done(irq_done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // one request; returns at the negedge after the response edge
    task automatic xfer(input logic we, input logic [7:0] a, input logic [3:0] be,
                        input logic [31:0] d, output logic [31:0] rd, output logic vld);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        rd = rsp_rdata; vld = rsp_valid;
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] r; logic v;
        xfer(1'b1, a, be, d, r, v);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] r);
        logic v;
        xfer(1'b0, a, 4'h0, 32'h0, r, v);
    endtask

    task automatic pulse_done();
        @(negedge clk); dp_done = 1'b1;
        @(negedge clk); dp_done = 1'b0;
    endtask

    // {addr, be, wdata, expected readback}
    localparam int NV = 10;
    localparam logic [75:0] TBL [NV] = '{
        {8'h40, 4'hF, 32'h1234_5678, 32'h1234_5678},  // R1
        {8'h44, 4'hF, 32'hCAFE_F00D, 32'hCAFE_F00D},  // R1
        {8'h48, 4'hF, 32'h0BAD_BEEF, 32'h0BAD_BEEF},  // R1
        {8'h40, 4'h2, 32'hFFFF_AAFF, 32'h1234_AA78},  // R1 byte enable
        {8'h4C, 4'hF, 32'h0040_0060, 32'h0040_0060},  // R2 K=64 M=96
        {8'h4C, 4'hC, 32'h0010_9999, 32'h0010_0060},  // R2 upper half only
        {8'h50, 4'hF, 32'h0000_0040, 32'h0000_0040},  // R2 N
        {8'h54, 4'hF, 32'hFFFF_FFFF, 32'h0000_5F80},  // R3 mask
        {8'h54, 4'hF, 32'h0000_0480, 32'h0000_0480},  // R3 GEMM + FP16
        {8'h54, 4'h1, 32'h0000_0000, 32'h0000_0400}   // R3 byte 0 clears fmt
    };

    initial begin
        logic [31:0] r; logic v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        check("R11 rsp_valid idle", {31'b0, rsp_valid}, 32'h0);
        check("R11 dp_start", {31'b0, dp_start}, 32'h0);
        check("R11 irq_done", {31'b0, irq_done}, 32'h0);
        rd(8'h40, r); check("R11 X ptr", r, 32'h0);
        rd(8'h0C, r); check("R11 status", r, 32'h0);

        // R1 R2 R3 table walk
        for (int i = 0; i < NV; i++) begin
            wr(TBL[i][75:68], TBL[i][67:64], TBL[i][63:32]);
            rd(TBL[i][75:68], r);
            check($sformatf("R1/R2/R3 vec %0d", i), r, TBL[i][31:0]);
        end

        // R10 timing and unmapped
        xfer(1'b0, 8'h08, 4'h0, 32'h0, r, v);
        check("R10 rsp_valid", {31'b0, v}, 32'h1);
        check("R10 unmapped 0x08", r, 32'h0);
        rd(8'h60, r); check("R10 unmapped 0x60", r, 32'h0);
        xfer(1'b1, 8'h44, 4'hF, 32'h5555_AAAA, r, v);
        check("R10 write rsp zero", r, 32'h0);
        @(negedge clk);
        check("R10 no rsp without req", {31'b0, rsp_valid}, 32'h0);

        // R4 trigger
        wr(8'h00, 4'hF, 32'h1);
        check("R4 start high", {31'b0, dp_start}, 32'h1);
        @(negedge clk);
        check("R4 start one cycle", {31'b0, dp_start}, 32'h0);
        rd(8'h0C, r); check("R4/R9 status busy", r, 32'h1);

        // R7 write while busy
        wr(8'h40, 4'hF, 32'hDEAD_0000);
        rd(8'h40, r); check("R7 X ptr frozen", r, 32'h1234_AA78);

        // R5 trigger while busy
        wr(8'h00, 4'hF, 32'h1);
        check("R5 no start", {31'b0, dp_start}, 32'h0);
        rd(8'h0C, r); check("R5 status", r, 32'h1);

        // R6 done
        pulse_done();
        check("R6 irq_done", {31'b0, irq_done}, 32'h1);
        rd(8'h0C, r); check("R6/R9 status done", r, 32'h2);
        pulse_done();
        rd(8'h0C, r); check("R6 idle done no effect", r, 32'h2);

        // R4 retrigger clears done
        wr(8'h00, 4'hF, 32'h1);
        check("R4 restart", {31'b0, dp_start}, 32'h1);
        rd(8'h0C, r); check("R4 done cleared", r, 32'h1);

        // R8 soft clear while busy
        wr(8'h04, 4'hF, 32'h1);
        check("R8 irq_done low", {31'b0, irq_done}, 32'h0);
        rd(8'h0C, r); check("R8 status", r, 32'h0);
        rd(8'h40, r); check("R8 X ptr", r, 32'h0);
        rd(8'h4C, r); check("R8 dims", r, 32'h0);
        rd(8'h54, r); check("R8 arith", r, 32'h0);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule